// File: doc/BRIEF.md
# Odd-Multiple Coefficient Product Generator

This block forms the signed product of one filter coefficient and a 4-bit input nibble, for all sixteen nibble values. It keeps no sixteen-entry table. A bank of four base words holds the odd multiples 1h, 3h, 5h and 7h of the loaded coefficient h. Each product is rebuilt from one of those words. An even multiple comes from a left shift of 0 to 3 places. A nibble with its top bit set is read as a negative two's-complement value, and its product is the two's-complement negation of the matching positive product. The block sits in front of a shift-accumulator that adds products across taps.

A coefficient load captures the new value. The base words are rebuilt on the next clock edge. Reads that still see the old words during this window carry a cleared valid flag. The output is registered.

Top module: `scp_prodgen`

## Requirements
- R1: Each read returns the coefficient times the nibble, both taken as two's-complement numbers (nibbles 8 to 15 count as their value minus 16). The product is COEF_W+4 bits wide and never overflows, including coefficient -2^(COEF_W-1) times nibble 8.
- R2: Nibble 0 yields a product of exactly zero for every coefficient.
- R3: For every nibble a from 1 to 7, the products at a and at 16-a are two's-complement negations of each other.
- R4: The product and prod_valid_o show a read on the rising edge that samples sample_i high together with addr_i. prod_valid_o is 1 for a read that is clear of any load.
- R5: When sample_i is low at an edge, prod_o keeps its value and prod_valid_o is 0 after that edge.
- R6: A load is sampled at edge k. Reads sampled at edges k and k+1 return products of the previous coefficient with prod_valid_o 0. A read at edge k+2 returns the new coefficient's product with prod_valid_o 1.
- R7: While reset is active, prod_o is 0, prod_valid_o is 0, and the stored coefficient is 0.
- R8: Loads on consecutive edges extend the invalid window to the edge after the last load. Reads from the edge after that return the last coefficient loaded.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coef_load_i | input | 1 | Load strobe for a new coefficient |
| coef_i | input | COEF_W | Signed coefficient to load |
| sample_i | input | 1 | Read enable for the product register |
| addr_i | input | 4 | Input nibble used as the table address |
| prod_o | output | COEF_W+4 | Registered signed product |
| prod_valid_o | output | 1 | Product was made from the current coefficient's base words |

## Verification
Directed sweeps over all sixteen nibbles use positive, negative and extreme coefficients. They separate shift errors (even nibbles), complement errors (the upper half, checked against the mirrored lower half) and word-select errors (the odd nibbles 3, 5 and 7). Reads issued in the same cycle as a load, or one cycle after it, and reads during back-to-back loads, show whether the old and new base words are told apart by the valid flag. Random coefficients with random nibbles and idle cycles, from a fixed seed, exercise the product against a bench model and check the hold-on-idle behaviour.

// File: rtl/scp_pkg.sv
package scp_pkg;

  // nibble width drives the whole odd-multiple scheme
  localparam int unsigned NIB_W    = 4;
  localparam int unsigned NUM_BASE = 1 << (NIB_W - 2);
  localparam int unsigned SEL_W    = NIB_W - 2;
  localparam int unsigned SHF_W    = $clog2(NIB_W);

  // decoded read control: which base word, how far to shift, sign, zero
  typedef struct packed {
    logic             zero;
    logic             neg;
    logic [SEL_W-1:0] sel;
    logic [SHF_W-1:0] shift;
  } scp_ctl_t;

endpackage

// File: rtl/scp_decode.sv
module scp_decode
  import scp_pkg::*;
(
  input  logic [NIB_W-1:0] addr_i,
  output scp_ctl_t         ctl_o
);

  logic [NIB_W-1:0] mag;
  logic [SHF_W-1:0] tz;

  // magnitude of the signed nibble; the most negative value maps to 2^(NIB_W-1)
  always_comb begin
    if (addr_i[NIB_W-1]) begin
      mag = ~addr_i + 1'b1;
    end else begin
      mag = addr_i;
    end
  end

  // lowest set bit of the magnitude gives the shift count
  always_comb begin
    tz = '0;
    for (int i = NIB_W - 1; i >= 0; i--) begin
      if (mag[i]) begin
        tz = SHF_W'(i);
      end
    end
  end

  always_comb begin
    ctl_o.zero  = (mag == '0);
    ctl_o.neg   = addr_i[NIB_W-1];
    ctl_o.shift = tz;
    // odd part is (mag >> tz); its upper bits index the odd-multiple bank
    ctl_o.sel   = SEL_W'(mag >> (tz + 1'b1));
  end

endmodule

// File: rtl/scp_base_bank.sv
module scp_base_bank
  import scp_pkg::*;
#(
  parameter int unsigned COEF_W = 16,
  localparam int unsigned BASE_W = COEF_W + NIB_W - 1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             load_i,
  input  logic [COEF_W-1:0]                coef_i,
  output logic [NUM_BASE-1:0][BASE_W-1:0]  words_o,
  output logic                             pend_o
);

  logic [COEF_W-1:0]               coef_q, coef_d;
  logic                            pend_q, pend_d;
  logic [NUM_BASE-1:0][BASE_W-1:0] words_q, words_d;
  logic [NUM_BASE-1:0][BASE_W-1:0] calc;
  logic signed [BASE_W-1:0]        coef_ext;

  assign coef_ext = {{(NIB_W-1){coef_q[COEF_W-1]}}, coef_q};

  // odd multiples (2i+1)*h, one per base word
  for (genvar gi = 0; gi < NUM_BASE; gi++) begin : g_odd
    localparam logic signed [BASE_W-1:0] ODD_K = BASE_W'(2 * gi + 1);
    logic signed [BASE_W-1:0] mult;
    assign mult     = coef_ext * ODD_K;
    assign calc[gi] = mult;
  end

  // next state: coefficient on load, bank one edge later
  always_comb begin
    coef_d  = coef_q;
    pend_d  = 1'b0;
    words_d = words_q;
    if (load_i) begin
      coef_d = coef_i;
      pend_d = 1'b1;
    end
    if (pend_q) begin
      words_d = calc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coef_q  <= '0;
      pend_q  <= 1'b0;
      words_q <= '0;
    end else begin
      coef_q  <= coef_d;
      pend_q  <= pend_d;
      words_q <= words_d;
    end
  end

  assign words_o = words_q;
  assign pend_o  = pend_q;

  AST_PEND_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !load_i) |=> !pend_q); // R8

  AST_PEND_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pend_q); // R6

endmodule

// File: rtl/scp_shift_neg.sv
module scp_shift_neg
  import scp_pkg::*;
#(
  parameter int unsigned COEF_W = 16,
  localparam int unsigned BASE_W = COEF_W + NIB_W - 1,
  localparam int unsigned PROD_W = COEF_W + NIB_W
) (
  input  logic [NUM_BASE-1:0][BASE_W-1:0] words_i,
  input  scp_ctl_t                        ctl_i,
  output logic [PROD_W-1:0]               prod_o
);

  logic [BASE_W-1:0]        word;
  logic signed [PROD_W-1:0] ext;
  logic signed [PROD_W-1:0] shifted;

  always_comb begin
    word    = words_i[ctl_i.sel];
    ext     = {word[BASE_W-1], word};
    shifted = ext <<< ctl_i.shift;
    if (ctl_i.zero) begin
      prod_o = '0;
    end else if (ctl_i.neg) begin
      prod_o = -shifted;
    end else begin
      prod_o = shifted;
    end
  end

endmodule

// File: rtl/scp_prodgen.sv
module scp_prodgen
  import scp_pkg::*;
#(
  parameter int unsigned COEF_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    coef_load_i,
  input  logic [COEF_W-1:0]       coef_i,
  input  logic                    sample_i,
  input  logic [NIB_W-1:0]        addr_i,
  output logic [COEF_W+NIB_W-1:0] prod_o,
  output logic                    prod_valid_o
);

  localparam int unsigned BASE_W = COEF_W + NIB_W - 1;
  localparam int unsigned PROD_W = COEF_W + NIB_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_nq;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q  <= 1'b0;
      rst_sync_nq <= 1'b0;
    end else begin
      rst_meta_q  <= 1'b1;
      rst_sync_nq <= rst_meta_q;
    end
  end

  logic [NUM_BASE-1:0][BASE_W-1:0] words;
  logic                            pend;
  scp_ctl_t                        ctl;
  logic [PROD_W-1:0]               prod_comb;

  scp_base_bank #(.COEF_W(COEF_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_nq),
    .load_i  (coef_load_i),
    .coef_i  (coef_i),
    .words_o (words),
    .pend_o  (pend)
  );

  scp_decode u_dec (
    .addr_i (addr_i),
    .ctl_o  (ctl)
  );

  scp_shift_neg #(.COEF_W(COEF_W)) u_sn (
    .words_i (words),
    .ctl_i   (ctl),
    .prod_o  (prod_comb)
  );

  logic [PROD_W-1:0] prod_q, prod_d;
  logic              vld_q, vld_d;

  always_comb begin
    prod_d = prod_q;
    vld_d  = 1'b0;
    if (sample_i) begin
      prod_d = prod_comb;
      vld_d  = !coef_load_i && !pend;
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_nq) begin
    if (!rst_sync_nq) begin
      prod_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      prod_q <= prod_d;
      vld_q  <= vld_d;
    end
  end

  assign prod_o       = prod_q;
  assign prod_valid_o = vld_q;

  AST_ZERO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_sync_nq)
    (sample_i && addr_i == '0) |=> (prod_o == '0)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_sync_nq)
    !sample_i |=> ($stable(prod_o) && !prod_valid_o)); // R5

  AST_LOAD_SAME_EDGE: assert property (@(posedge clk_i) disable iff (!rst_sync_nq)
    coef_load_i |=> !prod_valid_o); // R6

  AST_LOAD_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_sync_nq)
    $past(coef_load_i) |=> !prod_valid_o); // R6

endmodule

// File: tb/scp_prodgen_bench.sv
module scp_prodgen_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int PW = CW + 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load;
  logic [CW-1:0] coef;
  logic          sample;
  logic [3:0]    addr;
  logic [PW-1:0] prod;
  logic          vld;

  int n_tests = 0;
  int n_fail  = 0;
  logic [CW-1:0] cur_coef;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scp_prodgen #(.COEF_W(CW)) u_scp_prodgen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .coef_load_i  (load),
    .coef_i       (coef),
    .sample_i     (sample),
    .addr_i       (addr),
    .prod_o       (prod),
    .prod_valid_o (vld)
  );

  function automatic logic [PW-1:0] model(logic [CW-1:0] c, logic [3:0] a);
    longint cv = longint'($signed(c));
    longint av = (a >= 4'd8) ? longint'(a) - 16 : longint'(a);
    return PW'(cv * av);
  endfunction

  task automatic check(string req, logic [PW-1:0] exp_p, logic exp_v);
    n_tests++;
    if (prod !== exp_p || vld !== exp_v) begin
      n_fail++;
      $display("FAIL %s: prod=%0d valid=%0b expected prod=%0d valid=%0b",
               req, $signed(prod), vld, $signed(exp_p), exp_v);
    end
  endtask

  task automatic do_load(logic [CW-1:0] v);
    @(negedge clk);
    load = 1'b1; coef = v; sample = 1'b0;
    @(negedge clk);
    load = 1'b0;
    @(posedge clk);
    cur_coef = v;
  endtask

  task automatic do_read(string req, logic [3:0] a);
    @(negedge clk);
    sample = 1'b1; addr = a;
    @(posedge clk); #1;
    check(req, model(cur_coef, a), 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [PW-1:0] held;
    logic [PW-1:0] pa;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; load = 1'b0; coef = '0; sample = 1'b0; addr = '0;
    cur_coef = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset", '0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R7: stored coefficient is zero after reset
    do_read("R7 zero coef", 4'd5);

    // R1: sweep all nibbles with assorted coefficients
    do_load(16'd1234);
    for (int a = 0; a < 16; a++) do_read("R1 sweep pos", 4'(a));
    do_load(16'hF00D);
    for (int a = 0; a < 16; a++) do_read("R1 sweep neg", 4'(a));
    // R1 extremes: no overflow at full scale
    do_load(16'h8000);
    do_read("R1 min*-8", 4'd8);
    do_read("R1 min*7", 4'd7);
    do_load(16'h7FFF);
    do_read("R1 max*-8", 4'd8);
    do_read("R1 max*-1", 4'd15);

    // R2: nibble zero with nonzero coefficient
    do_read("R2 zero addr", 4'd0);

    // R3: mirrored addresses negate
    do_load(16'd7777);
    for (int a = 1; a < 8; a++) begin
      do_read("R3 low", 4'(a));
      pa = prod;
      do_read("R3 high", 4'(16 - a));
      n_tests++;
      if (prod !== PW'(-$signed(pa))) begin
        n_fail++;
        $display("FAIL R3: prod=%0d expected %0d", $signed(prod), -$signed(pa));
      end
    end

    // R4/R5: hold while idle
    do_read("R4 read", 4'd6);
    held = prod;
    @(negedge clk); sample = 1'b0; addr = 4'd3;
    @(posedge clk); #1;
    check("R5 hold", held, 1'b0);

    // R6: reads overlapping a load see the old words, flagged invalid
    @(negedge clk); load = 1'b1; coef = 16'd321; sample = 1'b1; addr = 4'd3;
    @(posedge clk); #1;
    check("R6 same edge", model(16'd7777, 4'd3), 1'b0);
    @(negedge clk); load = 1'b0; addr = 4'd5;
    @(posedge clk); #1;
    check("R6 next edge", model(16'd7777, 4'd5), 1'b0);
    cur_coef = 16'd321;
    @(negedge clk); addr = 4'd5;
    @(posedge clk); #1;
    check("R6 settled", model(16'd321, 4'd5), 1'b1);

    // R8: back-to-back loads
    @(negedge clk); load = 1'b1; coef = 16'd100; sample = 1'b0;
    @(negedge clk); load = 1'b1; coef = 16'hFF9C;
    @(negedge clk); load = 1'b0; sample = 1'b1; addr = 4'd9;
    @(posedge clk); #1;
    check("R8 window", model(16'd100, 4'd9), 1'b0);
    cur_coef = 16'hFF9C;
    @(negedge clk); addr = 4'd9;
    @(posedge clk); #1;
    check("R8 last coef", model(16'hFF9C, 4'd9), 1'b1);

    // R1/R5 random
    for (int it = 0; it < 200; it++) begin
      do_load(CW'($urandom));
      for (int r = 0; r < 4; r++) begin
        if ($urandom_range(0, 3) == 0) begin
          held = prod;
          @(negedge clk); sample = 1'b0; addr = 4'($urandom);
          @(posedge clk); #1;
          check("R5 random idle", held, 1'b0);
        end else begin
          do_read("R1 random", 4'($urandom));
        end
      end
    end

    @(negedge clk); sample = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule